// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers a set of interrupt sources into one pending register, gates it with a software-owned enable register and reports the most urgent priority level that may currently interrupt the core. Each source carries a fixed priority level and a fixed trigger type, both given as parameters. Level-type sources follow their line: they set on an active report and clear on an inactive one. Edge-type sources latch their bit until software clears it.

Source activity arrives as indexed events. An event names either an internal source number directly or an external pin number. A pin number is turned into a source number through a parameter table. Indices that fall outside the configured range are dropped and raise a one-cycle error flag. Software can write the enable register, trigger sources with a write-one-to-set port, and clear latched edge bits with a write-one-to-clear port.

Each cycle a priority scan takes the enabled pending vector. It walks the levels from the top configured level down to the level just above the core's current level, and picks the first level whose sources overlap the vector. A two-state request machine registers the result. In `ST_IDLE` the request is low. The transition `IDLE_TO_PEND` fires when the scan finds a level. In `ST_PEND` the request is high, and the transition `PEND_TO_IDLE` fires when the scan finds nothing. Both states hold otherwise.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pending source takes part in the scan only while its enable bit is 1. Writing the enable register to 0 removes every request one cycle after the write.
- R2: `pend_level` is the highest level L with NUM_LVL >= L > `cur_level` for which some source of level L is both pending and enabled. Sources configured with level 0 never produce a request. In the default configuration, source i has level i mod 8.
- R3: When no level qualifies, `pend_level` is 0 and `irq_req` is 0. `irq_req` is 1 exactly when `pend_level` is nonzero.
- R4: An event with `ev_active`=1 sets the target source's bit in `pend_vec` on the next clock edge. `sw_set_we` sets every bit that is 1 in `sw_set_data`.
- R5: An event with `ev_active`=0 clears the target bit of a level-type source and leaves an edge-type source's bit set. In the default configuration, source i is edge-type when (i mod 8) >= 4.
- R6: A direct event (`ev_is_pin`=0) with `ev_idx` >= NUM_SRC changes no bit and drives `idx_err` high for one cycle after the edge.
- R7: A pin event (`ev_is_pin`=1) acts on source PIN_MAP[`ev_idx`]. In the default configuration, pin p maps to source (5p+2) mod NUM_SRC. A pin index >= NUM_PINS is rejected in the same way as in R6.
- R8: `sw_clr_we` clears only those bits of `sw_clr_data` that belong to edge-type sources. Level-type bits are kept.
- R9: `pend_vec` reflects an event or software write after one clock edge. `pend_level` and `irq_req` reflect a change of the pending vector, the enable register or `cur_level` one edge after that change.
- R10: When a set and a clear hit the same bit in one cycle, the set wins.
- R11: After reset, `pend_vec`, the enable register, `pend_level`, `irq_req` and `idx_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Source event strobe |
| ev_is_pin | input | 1 | 1: `ev_idx` is an external pin number; 0: a source number |
| ev_idx | input | IDX_W | Event index |
| ev_active | input | 1 | 1: source asserted; 0: source deasserted |
| sw_en_we | input | 1 | Enable register write strobe |
| sw_en_data | input | NUM_SRC | New enable register value |
| sw_set_we | input | 1 | Write-one-to-set strobe |
| sw_set_data | input | NUM_SRC | Bits to set |
| sw_clr_we | input | 1 | Write-one-to-clear strobe (edge-type bits only) |
| sw_clr_data | input | NUM_SRC | Bits to clear |
| cur_level | input | LVL_W | Core's current interrupt level |
| pend_vec | output | NUM_SRC | Pending register |
| pend_level | output | LVL_W | Winning level, 0 when none |
| irq_req | output | 1 | Interrupt request to the core |
| idx_err | output | 1 | Out-of-range index flag |

## Verification
A wrong pending bit appears on `pend_vec` one edge after the event that caused it. On the following edge it appears on `pend_level` if the bit belongs to the top qualifying level. A scan that skips the threshold or the priority order shows a wrong `pend_level` in the cycle after the change of `cur_level` or of the enable register. A request machine stuck in either state breaks the agreement between `irq_req` and `pend_level` within one cycle. The bench keeps a behavioural model of the pending and enable registers and compares all outputs on every clock. It also drives each trigger type, the pin table, rejected indices and the set-versus-clear collision.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DEF_SRC  = 24;
    localparam int DEF_LVL  = 7;
    localparam int DEF_PINS = 8;
    localparam int DEF_LW   = 3;
    localparam int DEF_MW   = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } req_state_e;

    // Default source levels: source i sits at level i mod 8.
    function automatic logic [DEF_SRC*DEF_LW-1:0] def_levels();
        logic [DEF_SRC*DEF_LW-1:0] r;
        r = '0;
        for (int i = 0; i < DEF_SRC; i++) begin
            r[i*DEF_LW +: DEF_LW] = DEF_LW'(i % 8);
        end
        return r;
    endfunction

    // Default trigger types: 1 marks an edge-type source.
    function automatic logic [DEF_SRC-1:0] def_edge();
        logic [DEF_SRC-1:0] r;
        r = '0;
        for (int i = 0; i < DEF_SRC; i++) begin
            r[i] = ((i % 8) >= 4);
        end
        return r;
    endfunction

    // Default pin table: pin p drives source (5p+2) mod DEF_SRC.
    function automatic logic [DEF_PINS*DEF_MW-1:0] def_pin_map();
        logic [DEF_PINS*DEF_MW-1:0] r;
        r = '0;
        for (int p = 0; p < DEF_PINS; p++) begin
            r[p*DEF_MW +: DEF_MW] = DEF_MW'((p * 5 + 2) % DEF_SRC);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ev_decode.sv
module irq_ev_decode #(
    parameter int NUM_SRC  = 24,
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 6,
    parameter int MAP_W    = 5,
    parameter logic [NUM_PINS*MAP_W-1:0] PIN_MAP = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_is_pin,
    input  logic [IDX_W-1:0]   ev_idx,
    input  logic               ev_active,
    output logic [NUM_SRC-1:0] ev_set,
    output logic [NUM_SRC-1:0] ev_drop,
    output logic               err_q
);

    logic             hit;
    logic             bad;
    logic [MAP_W-1:0] mapped;
    int               tgt;

    always_comb begin
        mapped = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(ev_idx) == p) begin
                mapped = PIN_MAP[p*MAP_W +: MAP_W];
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        tgt = 0;
        if (ev_valid) begin
            if (ev_is_pin) begin
                if (int'(ev_idx) < NUM_PINS && int'(mapped) < NUM_SRC) begin
                    hit = 1'b1;
                    tgt = int'(mapped);
                end else begin
                    bad = 1'b1;
                end
            end else if (int'(ev_idx) < NUM_SRC) begin
                hit = 1'b1;
                tgt = int'(ev_idx);
            end else begin
                bad = 1'b1;
            end
        end
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_tgt
            assign ev_set[i]  = hit && ev_active  && (tgt == i);
            assign ev_drop[i] = hit && !ev_active && (tgt == i);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad;
        end
    end

    // R6: a direct index past the source count is flagged on the next cycle
    p_direct_range_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_is_pin && int'(ev_idx) >= NUM_SRC) |=> err_q);

    // R7: a pin index past the pin count is flagged on the next cycle
    p_pin_range_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_is_pin && int'(ev_idx) >= NUM_PINS) |=> err_q);

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NUM_SRC = 24,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] ev_set,
    input  logic [NUM_SRC-1:0] ev_drop,
    input  logic               sw_set_we,
    input  logic [NUM_SRC-1:0] sw_set_data,
    input  logic               sw_clr_we,
    input  logic [NUM_SRC-1:0] sw_clr_data,
    output logic [NUM_SRC-1:0] pend_q
);

    localparam logic [NUM_SRC-1:0] LEVEL_MASK = ~EDGE_MASK;

    logic [NUM_SRC-1:0] sets;
    logic [NUM_SRC-1:0] clrs;

    always_comb begin
        sets = ev_set;
        if (sw_set_we) begin
            sets = sets | sw_set_data;
        end
        clrs = ev_drop & LEVEL_MASK;
        if (sw_clr_we) begin
            clrs = clrs | (sw_clr_data & EDGE_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clrs) | sets;
        end
    end

    // R5: without a software clear, latched edge bits never drop
    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clr_we |=> ((pend_q & EDGE_MASK & $past(pend_q)) == ($past(pend_q) & EDGE_MASK)));

    // R8: a software clear never drops a level-type bit
    p_clr_spares_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_we && ev_drop == '0) |=> ((pend_q & LEVEL_MASK & $past(pend_q)) == ($past(pend_q) & LEVEL_MASK)));

    // R10: a software set always lands, even against a clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_we |=> ((pend_q & $past(sw_set_data)) == $past(sw_set_data)));

endmodule

// File: rtl/irq_lvl_scan.sv
module irq_lvl_scan #(
    parameter int NUM_SRC = 24,
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = 3,
    parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVEL = '0
) (
    input  logic [NUM_SRC-1:0] qual,
    input  logic [LVL_W-1:0]   cur_level,
    output logic [LVL_W-1:0]   win_level
);

    logic [NUM_SRC-1:0] lvl_mask [NUM_LVL+1];
    logic [NUM_LVL:0]   lvl_hit;

    generate
        for (genvar l = 0; l <= NUM_LVL; l++) begin : g_lvl
            for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
                if (l == 0) begin : g_none
                    assign lvl_mask[l][i] = 1'b0;
                end else begin : g_cmp
                    assign lvl_mask[l][i] = (int'(SRC_LEVEL[i*LVL_W +: LVL_W]) == l);
                end
            end
            assign lvl_hit[l] = |(lvl_mask[l] & qual);
        end
    endgenerate

    always_comb begin
        logic found;
        found     = 1'b0;
        win_level = '0;
        for (int l = NUM_LVL; l >= 1; l--) begin
            if (!found && l > int'(cur_level) && lvl_hit[l]) begin
                win_level = LVL_W'(l);
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC  = DEF_SRC,
    parameter int NUM_LVL  = DEF_LVL,
    parameter int NUM_PINS = DEF_PINS,
    parameter int IDX_W    = 6,
    parameter int LVL_W    = $clog2(NUM_LVL + 1),
    parameter int MAP_W    = $clog2(NUM_SRC),
    parameter logic [NUM_SRC*LVL_W-1:0]  SRC_LEVEL = def_levels(),
    parameter logic [NUM_SRC-1:0]        EDGE_MASK = def_edge(),
    parameter logic [NUM_PINS*MAP_W-1:0] PIN_MAP   = def_pin_map()
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_is_pin,
    input  logic [IDX_W-1:0]   ev_idx,
    input  logic               ev_active,
    input  logic               sw_en_we,
    input  logic [NUM_SRC-1:0] sw_en_data,
    input  logic               sw_set_we,
    input  logic [NUM_SRC-1:0] sw_set_data,
    input  logic               sw_clr_we,
    input  logic [NUM_SRC-1:0] sw_clr_data,
    input  logic [LVL_W-1:0]   cur_level,
    output logic [NUM_SRC-1:0] pend_vec,
    output logic [LVL_W-1:0]   pend_level,
    output logic               irq_req,
    output logic               idx_err
);

    logic [NUM_SRC-1:0] ev_set;
    logic [NUM_SRC-1:0] ev_drop;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic [LVL_W-1:0]   win_level;
    logic [LVL_W-1:0]   level_q;
    req_state_e         state_q;
    req_state_e         state_nx;

    irq_ev_decode #(
        .NUM_SRC  (NUM_SRC),
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W),
        .MAP_W    (MAP_W),
        .PIN_MAP  (PIN_MAP)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_is_pin (ev_is_pin),
        .ev_idx    (ev_idx),
        .ev_active (ev_active),
        .ev_set    (ev_set),
        .ev_drop   (ev_drop),
        .err_q     (idx_err)
    );

    irq_pend_reg #(
        .NUM_SRC   (NUM_SRC),
        .EDGE_MASK (EDGE_MASK)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_set      (ev_set),
        .ev_drop     (ev_drop),
        .sw_set_we   (sw_set_we),
        .sw_set_data (sw_set_data),
        .sw_clr_we   (sw_clr_we),
        .sw_clr_data (sw_clr_data),
        .pend_q      (pend_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (sw_en_we) begin
            en_q <= sw_en_data;
        end
    end

    irq_lvl_scan #(
        .NUM_SRC   (NUM_SRC),
        .NUM_LVL   (NUM_LVL),
        .LVL_W     (LVL_W),
        .SRC_LEVEL (SRC_LEVEL)
    ) u_scan (
        .qual      (pend_q & en_q),
        .cur_level (cur_level),
        .win_level (win_level)
    );

    // Request machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Request machine: transitions IDLE_TO_PEND and PEND_TO_IDLE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (win_level != '0) state_nx = ST_PEND;
            ST_PEND: if (win_level == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Request machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= win_level;
        end
    end

    assign irq_req    = (state_q == ST_PEND);
    assign pend_level = level_q;
    assign pend_vec   = pend_q;

    // R3: request and level agree
    p_req_tracks_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (pend_level != '0));

    // R2: a reported level lies above the threshold seen one edge earlier
    p_level_above_cur_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level != '0) |-> (int'(pend_level) > int'($past(cur_level))));

    // R1: with nothing enabled, no level is reported on the next cycle
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (pend_level == '0));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    localparam int NS = 24;
    localparam int NL = 7;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_is_pin = 1'b0;
    logic [5:0]    ev_idx = '0;
    logic          ev_active = 1'b0;
    logic          sw_en_we = 1'b0;
    logic [NS-1:0] sw_en_data = '0;
    logic          sw_set_we = 1'b0;
    logic [NS-1:0] sw_set_data = '0;
    logic          sw_clr_we = 1'b0;
    logic [NS-1:0] sw_clr_data = '0;
    logic [2:0]    cur_level = '0;
    logic [NS-1:0] pend_vec;
    logic [2:0]    pend_level;
    logic          irq_req;
    logic          idx_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_is_pin(ev_is_pin), .ev_idx(ev_idx), .ev_active(ev_active),
        .sw_en_we(sw_en_we), .sw_en_data(sw_en_data),
        .sw_set_we(sw_set_we), .sw_set_data(sw_set_data),
        .sw_clr_we(sw_clr_we), .sw_clr_data(sw_clr_data),
        .cur_level(cur_level),
        .pend_vec(pend_vec), .pend_level(pend_level), .irq_req(irq_req), .idx_err(idx_err)
    );

    // Behavioural reference
    bit [NS-1:0] m_set;
    bit [NS-1:0] m_en;
    int          m_level;
    bit          m_err;

    function automatic int lvl_of(int i);
        return i % 8;
    endfunction

    function automatic bit is_edge(int i);
        return (i % 8) >= 4;
    endfunction

    function automatic int scan(bit [NS-1:0] q, int cur);
        for (int l = NL; l > cur; l--) begin
            for (int i = 0; i < NS; i++) begin
                if (q[i] && lvl_of(i) == l) return l;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_set = '0; m_en = '0; m_level = 0; m_err = 0;
        end else begin
            int tgt;
            bit [NS-1:0] s;
            bit [NS-1:0] c;
            m_level = scan(m_set & m_en, int'(cur_level));
            m_err = 0;
            tgt = -1;
            s = '0;
            c = '0;
            if (ev_valid) begin
                if (ev_is_pin) begin
                    if (int'(ev_idx) < NP) tgt = (int'(ev_idx) * 5 + 2) % NS;
                    else m_err = 1;
                end else if (int'(ev_idx) < NS) tgt = int'(ev_idx);
                else m_err = 1;
            end
            if (tgt >= 0) begin
                if (ev_active) s[tgt] = 1'b1;
                else if (!is_edge(tgt)) c[tgt] = 1'b1;
            end
            if (sw_set_we) s = s | sw_set_data;
            if (sw_clr_we) begin
                for (int i = 0; i < NS; i++) if (sw_clr_data[i] && is_edge(i)) c[i] = 1'b1;
            end
            m_set = (m_set & ~c) | s;
            if (sw_en_we) m_en = sw_en_data;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (run && rst_n) begin
            check(pend_vec == m_set, "R4 pend_vec", int'(pend_vec), int'(m_set));
            check(int'(pend_level) == m_level, "R2 pend_level", int'(pend_level), m_level);
            check(irq_req == (m_level != 0), "R3 irq_req", int'(irq_req), int'(m_level != 0));
            check(idx_err == m_err, "R6 idx_err", int'(idx_err), int'(m_err));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(bit pin, int idx, bit act);
        @(negedge clk);
        ev_valid = 1'b1; ev_is_pin = pin; ev_idx = 6'(idx); ev_active = act;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic write_en(bit [NS-1:0] v);
        @(negedge clk);
        sw_en_we = 1'b1; sw_en_data = v;
        @(negedge clk);
        sw_en_we = 1'b0;
    endtask

    task automatic sw_write(bit set_we, bit [NS-1:0] sv, bit clr_we, bit [NS-1:0] cv);
        @(negedge clk);
        sw_set_we = set_we; sw_set_data = sv; sw_clr_we = clr_we; sw_clr_data = cv;
        @(negedge clk);
        sw_set_we = 1'b0; sw_clr_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        run = 1'b1;
        idle(1);
        // R11 reset state
        check(pend_vec == '0, "R11 reset pend_vec", int'(pend_vec), 0);
        check(pend_level == 0 && !irq_req && !idx_err, "R11 reset outputs", int'(pend_level), 0);

        write_en('1);
        // R4 / R2: level-type source 3 asserted
        send(0, 3, 1);
        check(pend_vec[3], "R4 set on active", int'(pend_vec[3]), 1);
        idle(1);
        check(pend_level == 3 && irq_req, "R2 level 3 wins", int'(pend_level), 3);

        // R9 / R2: threshold at 3 removes it one edge later
        @(negedge clk); cur_level = 3'd3;
        @(negedge clk);
        check(pend_level == 0 && !irq_req, "R9 threshold next cycle", int'(pend_level), 0);
        @(negedge clk); cur_level = 3'd0;
        idle(1);

        // R5: edge source 7 latches; level source 3 follows its line
        send(0, 7, 1);
        send(0, 7, 0);
        check(pend_vec[7], "R5 edge bit kept", int'(pend_vec[7]), 1);
        idle(1);
        check(pend_level == 7, "R2 highest level wins", int'(pend_level), 7);
        send(0, 3, 0);
        check(!pend_vec[3], "R5 level bit cleared", int'(pend_vec[3]), 0);

        // R8: software clear hits edge bit 7 only, level bit 3 kept
        send(0, 3, 1);
        sw_write(0, '0, 1, (NS'(1) << 7) | (NS'(1) << 3));
        check(!pend_vec[7] && pend_vec[3], "R8 clear edge only", int'(pend_vec), 32'h8);
        idle(1);
        check(pend_level == 3, "R8 level after clear", int'(pend_level), 3);

        // R6: direct index 30 rejected
        @(negedge clk);
        ev_valid = 1'b1; ev_is_pin = 1'b0; ev_idx = 6'd30; ev_active = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check(idx_err && pend_vec == 24'h8, "R6 bad index", int'(pend_vec), 32'h8);
        @(negedge clk);
        check(!idx_err, "R6 error is one cycle", int'(idx_err), 0);

        // R7: pin 1 maps to source 7; pin 9 rejected
        send(1, 1, 1);
        check(pend_vec[7], "R7 pin map", int'(pend_vec), 32'h88);
        @(negedge clk);
        ev_valid = 1'b1; ev_is_pin = 1'b1; ev_idx = 6'd9; ev_active = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check(idx_err && pend_vec == 24'h88, "R7 bad pin", int'(pend_vec), 32'h88);

        // R1: disabling everything removes the request
        write_en('0);
        @(negedge clk);
        check(pend_level == 0 && !irq_req, "R1 disabled", int'(pend_level), 0);
        write_en('1);
        idle(1);
        check(pend_level == 7, "R1 re-enabled", int'(pend_level), 7);

        // R10: set and clear of edge source 4 together
        sw_write(1, NS'(1) << 4, 1, NS'(1) << 4);
        check(pend_vec[4], "R10 set wins", int'(pend_vec[4]), 1);

        // R2: level-0 source never requests
        sw_write(0, '0, 1, '1);
        send(0, 3, 0);
        send(0, 0, 1);
        idle(1);
        check(pend_vec[0] && pend_level == 0 && !irq_req, "R2 level 0 silent", int'(pend_level), 0);

        // R2: threshold at the top level blocks everything
        sw_write(1, NS'(1) << 15, 0, '0);
        idle(1);
        check(pend_level == 7, "R2 source 15 level 7", int'(pend_level), 7);
        @(negedge clk); cur_level = 3'd7;
        @(negedge clk);
        check(pend_level == 0, "R2 top threshold", int'(pend_level), 0);

        idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule